// File: doc/BRIEF.md
# Programmable Parallel Port Register File

The block holds the register state of a set of simple-mode parallel I/O interfaces. Each interface has three 8-bit port latches, called A, B and C, and one control register. A host reaches these registers over a synchronous bus. The bus carries an instance number and a 2-bit register offset. Each latch drives an output bus of its own, so logic downstream always sees the current port values.

A write to the control offset does one of two things. If the data has bit 7 set, the data is a mode word and is stored whole. If bit 7 is clear, the data is a single-bit command that sets or clears one bit of port C. When a mode word asks for a handshake mode that the block does not support, a sticky per-instance flag is raised. The word is still stored.

The parameter `N_INST` sets how many instances are present, up to four. The instance select is always two bits wide. An access to a number above the populated range reads as zero and has no effect.

Top module: `ppr_regfile`

## Requirements
- R1: After reset, every instance holds 0x9B in its control register and 0xFF in ports A, B and C, and its unsupported flag is low. The read data is 0 and the read-valid output is low.
- R2: A write with offset 0 replaces port A of the selected instance with the written byte. Offset 1 does the same for port B and offset 2 for port C. The new value shows on that port's output bus in the cycle after the write.
- R3: A read (chip select and read enable high) returns the selected register on `rdata` in the following cycle, with `rdata_vld` high in exactly that cycle. Offsets 0, 1 and 2 return ports A, B and C, and offset 3 returns the control register.
- R4: A write to offset 3 with bit 7 set stores all eight bits in the control register. The port latches are not changed.
- R5: A write to offset 3 with bit 7 clear changes only port C bit n, where n is data bits 3:1. Data bit 0 gives the new value of that bit. Bits 6:4 have no effect, and the control register, ports A and B, and the flag are all unchanged.
- R6: A stored mode word with any of bits 6, 5 or 2 set (mask 0x64) raises the `unsup_o` bit of that instance in the next cycle.
- R7: The unsupported flag stays high through port writes and bit commands. Only reset, or a mode word with none of the mask 0x64 bits set, clears it.
- R8: An access whose instance number is N_INST or above changes no register. If it is a read, it returns 0 with `rdata_vld` high.
- R9: A write to one instance leaves the registers of every other instance unchanged.
- R10: When chip select is low, the write and read enables are ignored. No register changes and `rdata_vld` stays low.
- R11: When a read and a write hit the same register in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs | input | 1 | Chip select for the bus access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| inst_sel | input | 2 | Instance number |
| reg_off | input | 2 | Register offset (0 A, 1 B, 2 C, 3 control) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rdata_vld | output | 1 | High in the cycle that `rdata` answers a read |
| port_a_o | output | 8*N_INST | Port A latches, instance i at bits 8i+7:8i |
| port_b_o | output | 8*N_INST | Port B latches, same packing |
| port_c_o | output | 8*N_INST | Port C latches, same packing |
| unsup_o | output | N_INST | Sticky unsupported-mode flags, one per instance |

## Verification
The bench builds the block with `N_INST = 3`. This leaves instance number 3 unpopulated, so out-of-range reads and writes can be driven through the normal 2-bit select. With only three instances it is also cheap to sweep exhaustively. Every bit command from 0x00 to 0x7F is issued to each populated instance, and every mode word from 0x80 to 0xFF is stored and read back. The expected flag value is computed from the 0x64 mask, and a bench model compares all port buses of all instances after each write.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  localparam int DW          = 8;
  localparam int MODE_BIT    = 7;
  localparam int CMD_IDX_LSB = 1;
  localparam int CMD_IDX_W   = $clog2(DW);
  localparam int CMD_VAL_BIT = 0;

  typedef logic [DW-1:0] byte_t;

  typedef enum logic [1:0] {
    OFF_A    = 2'd0,
    OFF_B    = 2'd1,
    OFF_C    = 2'd2,
    OFF_CTRL = 2'd3
  } reg_off_e;

  localparam byte_t CTRL_RST   = 8'h9B;
  localparam byte_t PORT_RST   = 8'hFF;
  localparam byte_t UNSUP_MASK = 8'h64;
endpackage

// File: rtl/ppr_rst_sync.sv
module ppr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ain_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ain_n) begin
    if (!rst_ain_n) sync_q <= '0;
    else            sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ppr_decode.sv
module ppr_decode #(
  parameter int N_INST = 4,
  parameter int SEL_W  = 2
) (
  input  logic             cs_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [SEL_W-1:0] inst_sel_i,
  output logic [N_INST-1:0] unit_wr_o,
  output logic             sel_valid_o,
  output logic             rd_fire_o
);
  assign sel_valid_o = ({1'b0, inst_sel_i} < (SEL_W+1)'(N_INST));
  assign rd_fire_o   = cs_i & rd_en_i;

  for (genvar gi = 0; gi < N_INST; gi++) begin : g_wr
    assign unit_wr_o[gi] = cs_i & wr_en_i & sel_valid_o &
                           (inst_sel_i == SEL_W'(gi));
  end
endmodule

// File: rtl/ppr_unit.sv
module ppr_unit
  import ppr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_stb_i,
  input  reg_off_e reg_off_i,
  input  byte_t    wdata_i,
  output byte_t    port_a_o,
  output byte_t    port_b_o,
  output byte_t    port_c_o,
  output byte_t    ctrl_o,
  output logic     unsup_o
);
  byte_t a_q, b_q, c_q, ctrl_q;
  byte_t a_d, b_d, c_d, ctrl_d;
  logic  unsup_q, unsup_d;
  logic [CMD_IDX_W-1:0] cmd_idx;

  assign cmd_idx = wdata_i[CMD_IDX_LSB +: CMD_IDX_W];

  always_comb begin
    a_d     = a_q;
    b_d     = b_q;
    c_d     = c_q;
    ctrl_d  = ctrl_q;
    unsup_d = unsup_q;
    unique case (reg_off_i)
      OFF_A: a_d = wdata_i;
      OFF_B: b_d = wdata_i;
      OFF_C: c_d = wdata_i;
      OFF_CTRL: begin
        if (wdata_i[MODE_BIT]) begin
          ctrl_d  = wdata_i;
          unsup_d = |(wdata_i & UNSUP_MASK);
        end else begin
          c_d[cmd_idx] = wdata_i[CMD_VAL_BIT];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= PORT_RST;
      b_q     <= PORT_RST;
      c_q     <= PORT_RST;
      ctrl_q  <= CTRL_RST;
      unsup_q <= 1'b0;
    end else if (wr_stb_i) begin
      a_q     <= a_d;
      b_q     <= b_d;
      c_q     <= c_d;
      ctrl_q  <= ctrl_d;
      unsup_q <= unsup_d;
    end
  end

  assign port_a_o = a_q;
  assign port_b_o = b_q;
  assign port_c_o = c_q;
  assign ctrl_o   = ctrl_q;
  assign unsup_o  = unsup_q;
endmodule

// File: rtl/ppr_rdmux.sv
module ppr_rdmux
  import ppr_pkg::*;
#(
  parameter int N_INST = 4,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_fire_i,
  input  logic             sel_valid_i,
  input  logic [SEL_W-1:0] inst_sel_i,
  input  reg_off_e         reg_off_i,
  input  byte_t            a_i    [N_INST],
  input  byte_t            b_i    [N_INST],
  input  byte_t            c_i    [N_INST],
  input  byte_t            ctrl_i [N_INST],
  output byte_t            rdata_o,
  output logic             rdata_vld_o
);
  byte_t pick;
  byte_t rdata_d;
  byte_t rdata_q;
  logic  vld_q;

  always_comb begin
    pick = '0;
    for (int i = 0; i < N_INST; i++) begin
      if (inst_sel_i == SEL_W'(i)) begin
        unique case (reg_off_i)
          OFF_A:    pick = a_i[i];
          OFF_B:    pick = b_i[i];
          OFF_C:    pick = c_i[i];
          OFF_CTRL: pick = ctrl_i[i];
          default:  pick = '0;
        endcase
      end
    end
    rdata_d = sel_valid_i ? pick : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_fire_i) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= rd_fire_i;
  end

  assign rdata_o     = rdata_q;
  assign rdata_vld_o = vld_q;
endmodule

// File: rtl/ppr_regfile.sv
module ppr_regfile
  import ppr_pkg::*;
#(
  parameter int N_INST     = 4,
  parameter int SEL_W      = 2,
  parameter int RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [SEL_W-1:0]     inst_sel,
  input  logic [1:0]           reg_off,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic                 rdata_vld,
  output logic [N_INST*DW-1:0] port_a_o,
  output logic [N_INST*DW-1:0] port_b_o,
  output logic [N_INST*DW-1:0] port_c_o,
  output logic [N_INST-1:0]    unsup_o
);
  logic             rst_sync_n;
  logic [N_INST-1:0] unit_wr;
  logic             sel_valid;
  logic             rd_fire;
  reg_off_e         off_e;
  byte_t            a_arr    [N_INST];
  byte_t            b_arr    [N_INST];
  byte_t            c_arr    [N_INST];
  byte_t            ctrl_arr [N_INST];

  assign off_e = reg_off_e'(reg_off);

  ppr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_ain_n  (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ppr_decode #(.N_INST(N_INST), .SEL_W(SEL_W)) u_dec (
    .cs_i        (cs),
    .wr_en_i     (wr_en),
    .rd_en_i     (rd_en),
    .inst_sel_i  (inst_sel),
    .unit_wr_o   (unit_wr),
    .sel_valid_o (sel_valid),
    .rd_fire_o   (rd_fire)
  );

  for (genvar gi = 0; gi < N_INST; gi++) begin : g_unit
    ppr_unit u_unit (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wr_stb_i  (unit_wr[gi]),
      .reg_off_i (off_e),
      .wdata_i   (wdata),
      .port_a_o  (a_arr[gi]),
      .port_b_o  (b_arr[gi]),
      .port_c_o  (c_arr[gi]),
      .ctrl_o    (ctrl_arr[gi]),
      .unsup_o   (unsup_o[gi])
    );
    assign port_a_o[gi*DW +: DW] = a_arr[gi];
    assign port_b_o[gi*DW +: DW] = b_arr[gi];
    assign port_c_o[gi*DW +: DW] = c_arr[gi];
  end

  ppr_rdmux #(.N_INST(N_INST), .SEL_W(SEL_W)) u_rd (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rd_fire_i   (rd_fire),
    .sel_valid_i (sel_valid),
    .inst_sel_i  (inst_sel),
    .reg_off_i   (off_e),
    .a_i         (a_arr),
    .b_i         (b_arr),
    .c_i         (c_arr),
    .ctrl_i      (ctrl_arr),
    .rdata_o     (rdata),
    .rdata_vld_o (rdata_vld)
  );
endmodule

// File: rtl/ppr_regfile_chk.sv
module ppr_regfile_chk #(
  parameter int N_INST = 4,
  parameter int SEL_W  = 2,
  parameter int DW     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [SEL_W-1:0]     inst_sel,
  input logic [1:0]           reg_off,
  input logic [DW-1:0]        wdata,
  input logic [DW-1:0]        rdata,
  input logic                 rdata_vld,
  input logic [N_INST*DW-1:0] port_a_o,
  input logic [N_INST*DW-1:0] port_b_o,
  input logic [N_INST*DW-1:0] port_c_o,
  input logic [N_INST-1:0]    unsup_o
);
  logic in_range, wr_hit, cmd_hit, mode_hit;
  logic [SEL_W+2:0] cmd_pos;

  assign in_range = ({1'b0, inst_sel} < (SEL_W+1)'(N_INST));
  assign wr_hit   = cs && wr_en && in_range;
  assign cmd_hit  = wr_hit && (reg_off == 2'd3) && !wdata[7];
  assign mode_hit = wr_hit && (reg_off == 2'd3) && wdata[7];
  assign cmd_pos  = {inst_sel, wdata[3:1]};

  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd_en) |=> rdata_vld); // R3

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd_en && !in_range) |=> (rdata == '0)); // R8

  AST_OOR_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr_en && !in_range) |=> ($stable(port_a_o) && $stable(port_b_o) &&
                                    $stable(port_c_o) && $stable(unsup_o))); // R8

  AST_NO_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs) |=> (!rdata_vld && $stable(port_a_o) && $stable(port_b_o) &&
               $stable(port_c_o) && $stable(unsup_o))); // R10

  AST_CMD_BIT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> (port_c_o[$past(cmd_pos)] == $past(wdata[0]))); // R5

  AST_CMD_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> ($stable(port_a_o) && $stable(port_b_o) && $stable(unsup_o))); // R5

  AST_UNSUP_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hit && ((wdata & 8'h64) != 8'h00)) |=> unsup_o[$past(inst_sel)]); // R6

  AST_UNSUP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_hit) |=> $stable(unsup_o)); // R7
endmodule

bind ppr_regfile ppr_regfile_chk #(.N_INST(N_INST), .SEL_W(SEL_W), .DW(ppr_pkg::DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cs        (cs),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .inst_sel  (inst_sel),
  .reg_off   (reg_off),
  .wdata     (wdata),
  .rdata     (rdata),
  .rdata_vld (rdata_vld),
  .port_a_o  (port_a_o),
  .port_b_o  (port_b_o),
  .port_c_o  (port_c_o),
  .unsup_o   (unsup_o)
);

// File: tb/tb_ppr_regfile.sv
module tb_ppr_regfile;
  localparam int N = 3;

  logic clk, rst_n, cs, wr_en, rd_en;
  logic [1:0] inst_sel, reg_off;
  logic [7:0] wdata, rdata;
  logic rdata_vld;
  logic [N*8-1:0] port_a_o, port_b_o, port_c_o;
  logic [N-1:0] unsup_o;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] m_a [N];
  logic [7:0] m_b [N];
  logic [7:0] m_c [N];
  logic [7:0] m_ctrl [N];
  logic       m_uns [N];

  ppr_regfile #(.N_INST(N)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rd_en(rd_en),
    .inst_sel(inst_sel), .reg_off(reg_off), .wdata(wdata),
    .rdata(rdata), .rdata_vld(rdata_vld),
    .port_a_o(port_a_o), .port_b_o(port_b_o), .port_c_o(port_c_o),
    .unsup_o(unsup_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_ports(string req);
    for (int i = 0; i < N; i++)
      chk(req, {port_a_o[i*8 +: 8], port_b_o[i*8 +: 8], port_c_o[i*8 +: 8], 7'd0, unsup_o[i]},
               {m_a[i], m_b[i], m_c[i], 7'd0, m_uns[i]});
  endtask

  task automatic model_wr(int inst, int off, logic [7:0] d);
    if (inst >= N) return;
    case (off)
      0: m_a[inst] = d;
      1: m_b[inst] = d;
      2: m_c[inst] = d;
      default: begin
        if (d >= 8'h80) begin
          m_ctrl[inst] = d;
          m_uns[inst]  = ((d & 8'h64) != 0);
        end else begin
          int pos = (d / 2) % 8;
          if (d % 2 == 1) m_c[inst] = m_c[inst] | (8'd1 << pos);
          else            m_c[inst] = m_c[inst] & ~(8'd1 << pos);
        end
      end
    endcase
  endtask

  task automatic bus_wr(int inst, int off, logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr_en = 1'b1; inst_sel = inst[1:0]; reg_off = off[1:0]; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr_en = 1'b0;
    model_wr(inst, off, d);
  endtask

  task automatic bus_rd(int inst, int off, output logic [7:0] d, output logic v);
    @(negedge clk);
    cs = 1'b1; rd_en = 1'b1; inst_sel = inst[1:0]; reg_off = off[1:0];
    @(negedge clk);
    d = rdata; v = rdata_vld;
    cs = 1'b0; rd_en = 1'b0;
  endtask

  function automatic logic [7:0] model_rd(int inst, int off);
    if (inst >= N) return 8'h00;
    case (off)
      0: return m_a[inst];
      1: return m_b[inst];
      2: return m_c[inst];
      default: return m_ctrl[inst];
    endcase
  endfunction

  initial begin
    logic [7:0] d;
    logic v;
    rst_n = 1'b0; cs = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    inst_sel = 2'd0; reg_off = 2'd0; wdata = 8'h00;
    for (int i = 0; i < N; i++) begin
      m_a[i] = 8'hFF; m_b[i] = 8'hFF; m_c[i] = 8'hFF; m_ctrl[i] = 8'h9B; m_uns[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 rdata", {24'd0, rdata}, 32'h0);
    chk("R1 rdata_vld", {31'd0, rdata_vld}, 32'h0);
    chk_ports("R1 ports");
    for (int i = 0; i < N; i++)
      for (int o = 0; o < 4; o++) begin
        bus_rd(i, o, d, v);
        chk("R1 readback", {23'd0, v, d}, {23'd0, 1'b1, model_rd(i, o)});
      end

    // R3: valid drops after the read cycle
    @(negedge clk);
    chk("R3 vld one cycle", {31'd0, rdata_vld}, 32'h0);

    // R2 R3 R9: port write sweep
    for (int k = 0; k < 16; k++)
      for (int i = 0; i < N; i++)
        for (int o = 0; o < 3; o++) begin
          logic [7:0] val;
          val = 8'((k * 53 + i * 29 + o * 7 + 1) % 256);
          bus_wr(i, o, val);
          chk_ports("R2 R9 port write");
          bus_rd(i, o, d, v);
          chk("R3 port readback", {23'd0, v, d}, {23'd0, 1'b1, val});
        end

    // R5: every bit command on every instance
    for (int i = 0; i < N; i++)
      for (int c = 0; c < 128; c++) begin
        bus_wr(i, 3, 8'(c));
        chk_ports("R5 bit command");
        if (c % 16 == 15) begin
          bus_rd(i, 3, d, v);
          chk("R5 ctrl unchanged", {24'd0, d}, {24'd0, m_ctrl[i]});
        end
      end

    // R4 R6: every mode word
    for (int w = 0; w < 128; w++) begin
      bus_wr(w % N, 3, 8'(w + 128));
      chk_ports("R4 R6 mode word");
      bus_rd(w % N, 3, d, v);
      chk("R4 mode readback", {24'd0, d}, 32'(w + 128));
    end

    // R7: sticky flag
    bus_wr(1, 3, 8'hA4);
    chk("R6 flag raised", {31'd0, unsup_o[1]}, 32'd1);
    bus_wr(1, 0, 8'h12);
    bus_wr(1, 3, 8'h05);
    bus_wr(1, 3, 8'h0E);
    bus_wr(1, 2, 8'h77);
    chk("R7 flag sticky", {31'd0, unsup_o[1]}, 32'd1);
    chk_ports("R7 sticky ports");
    bus_wr(1, 3, 8'h9B);
    chk("R7 flag cleared", {31'd0, unsup_o[1]}, 32'd0);
    chk_ports("R7 clear ports");

    // R8: out-of-range instance
    for (int o = 0; o < 4; o++) begin
      bus_wr(3, o, 8'h5A);
      chk_ports("R8 oor write");
      bus_rd(3, o, d, v);
      chk("R8 oor read", {23'd0, v, d}, {23'd0, 1'b1, 8'h00});
    end
    bus_wr(3, 3, 8'hE4);
    bus_wr(3, 3, 8'h01);
    chk_ports("R8 oor control");

    // R10: strobes without chip select
    @(negedge clk);
    cs = 1'b0; wr_en = 1'b1; rd_en = 1'b1; inst_sel = 2'd0; reg_off = 2'd0; wdata = 8'hC3;
    @(negedge clk);
    chk("R10 no vld", {31'd0, rdata_vld}, 32'h0);
    chk_ports("R10 no write");
    wr_en = 1'b0; rd_en = 1'b0;

    // R11: read and write in the same cycle
    @(negedge clk);
    cs = 1'b1; wr_en = 1'b1; rd_en = 1'b1; inst_sel = 2'd2; reg_off = 2'd1; wdata = 8'h3C;
    d = m_b[2];
    @(negedge clk);
    cs = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    model_wr(2, 1, 8'h3C);
    chk("R11 old value read", {23'd0, rdata_vld, rdata}, {23'd0, 1'b1, d});
    chk_ports("R11 write landed");

    report();
    $finish;
  end
endmodule